// File: doc/BRIEF.md
# Compliance Pattern Generator with Forced Disparity

This block produces the link-layer compliance test pattern and passes every symbol through an 8b/10b encoder. The pattern is a four-symbol loop: K28.5, D21.5, K28.5, D10.2. While compliance mode is enabled, the block steps through that loop. When compliance mode drops, it falls back to K28.5 fill. The first K28.5 after compliance mode is enabled must leave the transmitter at negative disparity. The encoder therefore treats that one symbol as if the running disparity were negative, whatever disparity was carried in. Every later repetition uses the disparity the encoder carried forward naturally.

A parameter selects the parallel width: one symbol per cycle, or two symbols per cycle. In the two-symbol form, the low lane is the earlier symbol on the line. Disparity passes from the low lane to the high lane within the cycle. The force lands on the low lane only, in the cycle that carries the K28.5/D21.5 pair. A force-marker output shows, lane by lane, where the override was applied. The running-disparity output gives the disparity after the last symbol of the current output word.

Top module: `cpat_gen`

## Requirements
- R1: While reset is held, `sym_out`, `force_mark` and `rd_out` are all zero. Zero on `rd_out` means negative running disparity, and one means positive. The pattern restarts from its first K28.5 after reset.
- R2: Each 10-bit lane holds the code in transmission order, with bit 9 sent first and bit 0 sent last. The codes are: K28.5 from negative disparity = 10'h0FA, K28.5 from positive disparity = 10'h305, D21.5 = 10'h2AA, D10.2 = 10'h155.
- R3: With `LANES`=1 and `cmp_en` high, one symbol is output per cycle in the order K28.5, D21.5, K28.5, D10.2, repeating. Each output appears on the clock edge that samples `cmp_en`.
- R4: With `LANES`=2, lane 0 (`sym_out[9:0]`) is the earlier symbol. The words alternate between {lane 1 = D21.5, lane 0 = K28.5} and {lane 1 = D10.2, lane 0 = K28.5}. Lane 1 is encoded with the disparity left by lane 0.
- R5: `rd_out` equals the running disparity after the highest lane of the word currently on `sym_out`.
- R6: Outside the forced symbol, every symbol is encoded with the disparity carried from the previous symbol, including across pattern repetitions and across idle fill.
- R7: In the first enabled cycle after `cmp_en` rises, lane 0 is K28.5 encoded from negative disparity (10'h0FA) even when the carried disparity is positive. `force_mark[0]` is high in that cycle.
- R8: `force_mark` is zero in every cycle except the first enabled cycle. No bit above bit 0 is ever set.
- R9: While `cmp_en` is low, every lane is K28.5 with disparity chained normally. In single-symbol mode, the fill therefore alternates between 10'h0FA and 10'h305.
- R10: Dropping `cmp_en` in the middle of the pattern and raising it again restarts the pattern at its first K28.5, with the force applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel-word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_en | input | 1 | Compliance mode enable |
| sym_out | output | 10*LANES | Encoded symbols; lane 0 in bits [9:0] is sent first |
| rd_out | output | 1 | Running disparity after the last lane (1 = positive) |
| force_mark | output | LANES | Per-lane flag: lane encoded with forced negative disparity |

## Verification
The hardest case is a re-enable that arrives while the carried disparity is positive. Only then does the override change the emitted code; otherwise the forced and natural encodings are identical. In single-symbol mode, the fill toggles disparity every cycle, so the stimulus chooses the length of the idle gap to land on positive disparity before raising the enable again. In two-symbol mode, the fill never changes disparity. Here the stimulus stops the pattern after an odd number of words, which leaves the disparity positive, and then re-enables.

// File: rtl/cpat_gen.sv
module cpat_gen #(
  parameter int LANES = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmp_en,
  output logic [10*LANES-1:0]   sym_out,
  output logic                  rd_out,
  output logic [LANES-1:0]      force_mark
);

  localparam int STEPS = 4 / LANES;
  localparam int PH_W  = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [7:0] B_K285 = 8'hBC;
  localparam logic [7:0] B_D215 = 8'hB5;
  localparam logic [7:0] B_D102 = 8'h4A;

  function automatic logic [10:0] enc_sym(input logic [7:0] b, input logic k, input logic rd);
    logic [4:0] x;
    logic [2:0] y;
    logic [5:0] t6, c6;
    logic [3:0] t4, c4;
    logic [9:0] code;
    logic rm, alt;
    x = b[4:0];
    y = b[7:5];
    case (x)
      5'd0:  t6 = 6'b100111;
      5'd1:  t6 = 6'b011101;
      5'd2:  t6 = 6'b101101;
      5'd3:  t6 = 6'b110001;
      5'd4:  t6 = 6'b110101;
      5'd5:  t6 = 6'b101001;
      5'd6:  t6 = 6'b011001;
      5'd7:  t6 = 6'b111000;
      5'd8:  t6 = 6'b111001;
      5'd9:  t6 = 6'b100101;
      5'd10: t6 = 6'b010101;
      5'd11: t6 = 6'b110100;
      5'd12: t6 = 6'b001101;
      5'd13: t6 = 6'b101100;
      5'd14: t6 = 6'b011100;
      5'd15: t6 = 6'b010111;
      5'd16: t6 = 6'b011011;
      5'd17: t6 = 6'b100011;
      5'd18: t6 = 6'b010011;
      5'd19: t6 = 6'b110010;
      5'd20: t6 = 6'b001011;
      5'd21: t6 = 6'b101010;
      5'd22: t6 = 6'b011010;
      5'd23: t6 = 6'b111010;
      5'd24: t6 = 6'b110011;
      5'd25: t6 = 6'b100110;
      5'd26: t6 = 6'b010110;
      5'd27: t6 = 6'b110110;
      5'd28: t6 = 6'b001110;
      5'd29: t6 = 6'b101110;
      5'd30: t6 = 6'b011110;
      default: t6 = 6'b101011;
    endcase
    if (k) t6 = 6'b001111;
    c6 = (rd && ($countones(t6) != 3 || x == 5'd7)) ? ~t6 : t6;
    rm = ($countones(c6) == 3) ? rd : ($countones(c6) > 3);
    alt = rm ? (x == 5'd11 || x == 5'd13 || x == 5'd14)
             : (x == 5'd17 || x == 5'd18 || x == 5'd20);
    if (k) begin
      case (y)
        3'd0: t4 = 4'b0100;
        3'd1: t4 = 4'b1001;
        3'd2: t4 = 4'b0101;
        3'd3: t4 = 4'b0011;
        3'd4: t4 = 4'b0010;
        3'd5: t4 = 4'b1010;
        3'd6: t4 = 4'b0110;
        default: t4 = 4'b1000;
      endcase
      c4 = rd ? ~t4 : t4;
    end else begin
      case (y)
        3'd0: t4 = 4'b1011;
        3'd1: t4 = 4'b1001;
        3'd2: t4 = 4'b0101;
        3'd3: t4 = 4'b1100;
        3'd4: t4 = 4'b1101;
        3'd5: t4 = 4'b1010;
        3'd6: t4 = 4'b0110;
        default: t4 = alt ? 4'b0111 : 4'b1110;
      endcase
      c4 = (rm && ($countones(t4) != 2 || y == 3'd3)) ? ~t4 : t4;
    end
    code = {c6, c4};
    enc_sym = {(($countones(code) == 5) ? rd : ($countones(code) > 5)), code};
  endfunction

  logic [PH_W-1:0]     phase;
  logic                en_q;
  logic                rd_q;
  logic [10*LANES-1:0] sym_q;
  logic [LANES-1:0]    frc_q;
  logic                start;
  logic [10*LANES-1:0] sym_n;
  logic                rd_n;
  logic [PH_W-1:0]     phase_n;

  assign start = cmp_en && !en_q;
  assign phase_n = !cmp_en ? '0 :
                   (phase == PH_W'(STEPS - 1)) ? '0 : phase + 1'b1;

  always_comb begin
    logic r;
    logic [1:0] pidx;
    logic [7:0] byt;
    logic [10:0] res;
    r = start ? 1'b0 : rd_q;
    sym_n = '0;
    for (int l = 0; l < LANES; l++) begin
      pidx = cmp_en ? 2'((int'(phase) * LANES + l) % 4) : 2'd0;
      case (pidx)
        2'd1:    byt = B_D215;
        2'd3:    byt = B_D102;
        default: byt = B_K285;
      endcase
      res = enc_sym(byt, !pidx[0], r);
      sym_n[l*10 +: 10] = res[9:0];
      r = res[10];
    end
    rd_n = r;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
      en_q  <= 1'b0;
      rd_q  <= 1'b0;
      sym_q <= '0;
      frc_q <= '0;
    end else begin
      phase <= phase_n;
      en_q  <= cmp_en;
      rd_q  <= rd_n;
      sym_q <= sym_n;
      frc_q <= {{(LANES-1){1'b0}}, start} & {LANES{1'b1}};
    end
  end

  assign sym_out    = sym_q;
  assign rd_out     = rd_q;
  assign force_mark = frc_q;

endmodule

module cpat_gen_chk #(
  parameter int LANES = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmp_en,
  input logic [10*LANES-1:0] sym_out,
  input logic                rd_out,
  input logic [LANES-1:0]    force_mark
);

  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R8
  frc_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(force_mark) <= 1 && (force_mark == '0 || force_mark[0]));

  // R7
  frc_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && force_mark[0] |-> sym_out[9:0] == 10'h0FA);

  // R7
  frc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && force_mark[0] |-> $past(cmp_en));

  // R9
  idle_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(cmp_en) |-> (sym_out[9:0] == 10'h0FA || sym_out[9:0] == 10'h305));

  // R5
  rd_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $countones(sym_out[10*LANES-1 -: 10]) != 5
    |-> rd_out == ($countones(sym_out[10*LANES-1 -: 10]) == 6));

  // R6
  rd_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !force_mark[0] && $countones(sym_out[9:0]) != 5
    |-> $past(rd_out) == ($countones(sym_out[9:0]) == 4));

  generate
    if (LANES > 1) begin : g_chain
      // R4
      lane_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $countones(sym_out[19:10]) != 5 && $countones(sym_out[9:0]) != 5
        |-> ($countones(sym_out[19:10]) == 4) == ($countones(sym_out[9:0]) == 6));
    end
  endgenerate

endmodule

bind cpat_gen cpat_gen_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en),
  .sym_out(sym_out), .rd_out(rd_out), .force_mark(force_mark)
);

// File: tb/tb_cpat_gen.sv
module tb_cpat_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en8 = 1'b0;
  logic en16 = 1'b0;
  logic [9:0]  sym8;
  logic        rd8;
  logic [0:0]  frc8;
  logic [19:0] sym16;
  logic        rd16;
  logic [1:0]  frc16;

  cpat_gen #(.LANES(1)) dut (
    .clk(clk), .rst_n(rst_n), .cmp_en(en8),
    .sym_out(sym8), .rd_out(rd8), .force_mark(frc8));

  cpat_gen #(.LANES(2)) dut_w (
    .clk(clk), .rst_n(rst_n), .cmp_en(en16),
    .sym_out(sym16), .rd_out(rd16), .force_mark(frc16));

  always #5 clk = ~clk;

  localparam logic [9:0] K_N = 10'h0FA;
  localparam logic [9:0] K_P = 10'h305;
  localparam logic [9:0] D21 = 10'h2AA;
  localparam logic [9:0] D10 = 10'h155;

  int checks = 0;
  int errors = 0;
  logic m_rd8 = 1'b0, m_en8 = 1'b0, m_rd16 = 1'b0, m_en16 = 1'b0;
  int m_ph8 = 0, m_ph16 = 0;

  function automatic logic [9:0] kcode(input logic rd);
    return rd ? K_P : K_N;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic e8, input logic e16, input string tag);
    logic [9:0] x8, a, b;
    logic f8;
    logic [1:0] f16;
    en8 = e8;
    en16 = e16;
    @(negedge clk);
    f8 = 1'b0;
    if (e8 && !m_en8) begin
      x8 = K_N; f8 = 1'b1; m_rd8 = 1'b1; m_ph8 = 1;
    end else if (e8) begin
      case (m_ph8)
        0, 2: begin x8 = kcode(m_rd8); m_rd8 = ~m_rd8; end
        1: x8 = D21;
        default: x8 = D10;
      endcase
      m_ph8 = (m_ph8 + 1) % 4;
    end else begin
      x8 = kcode(m_rd8); m_rd8 = ~m_rd8; m_ph8 = 0;
    end
    m_en8 = e8;
    f16 = 2'b00;
    if (e16 && !m_en16) begin
      a = K_N; b = D21; m_rd16 = 1'b1; f16 = 2'b01; m_ph16 = 1;
    end else if (e16) begin
      a = kcode(m_rd16); m_rd16 = ~m_rd16;
      b = (m_ph16 == 0) ? D21 : D10;
      m_ph16 = 1 - m_ph16;
    end else begin
      a = kcode(m_rd16); m_rd16 = ~m_rd16;
      b = kcode(m_rd16); m_rd16 = ~m_rd16;
      m_ph16 = 0;
    end
    m_en16 = e16;
    chk(tag, "sym 1-lane", 32'(sym8), 32'(x8));
    chk("R5", "rd 1-lane", 32'(rd8), 32'(m_rd8));
    chk(f8 ? "R7" : "R8", "force 1-lane", 32'(frc8), 32'(f8));
    chk(tag, "sym 2-lane", 32'(sym16), 32'({b, a}));
    chk("R5", "rd 2-lane", 32'(rd16), 32'(m_rd16));
    chk(f16[0] ? "R7" : "R8", "force 2-lane", 32'(frc16), 32'(f16));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "sym 1-lane", 32'(sym8), 0);
    chk("R1", "rd 1-lane", 32'(rd8), 0);
    chk("R1", "force 1-lane", 32'(frc8), 0);
    chk("R1", "sym 2-lane", 32'(sym16), 0);
    chk("R1", "force 2-lane", 32'(frc16), 0);
    rst_n = 1'b1;
    m_rd8 = 0; m_en8 = 0; m_ph8 = 0; m_rd16 = 0; m_en16 = 0; m_ph16 = 0;
  endtask

  task automatic t_idle();
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, "R9");
  endtask

  task automatic t_pattern8();
    cyc(1'b1, 1'b0, "R3");
    chk("R2", "first comma", 32'(sym8), 32'(10'h0FA));
    cyc(1'b1, 1'b0, "R3");
    chk("R2", "D21.5", 32'(sym8), 32'(10'h2AA));
    cyc(1'b1, 1'b0, "R3");
    chk("R2", "second comma", 32'(sym8), 32'(10'h305));
    cyc(1'b1, 1'b0, "R3");
    chk("R2", "D10.2", 32'(sym8), 32'(10'h155));
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, "R6");
  endtask

  task automatic t_force8();
    cyc(1'b0, 1'b0, "R9");
    cyc(1'b0, 1'b0, "R9");
    chk("R7", "carried rd before re-enable", 32'(rd8), 1);
    cyc(1'b1, 1'b0, "R7");
    chk("R7", "forced comma", 32'(sym8), 32'(10'h0FA));
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, "R6");
  endtask

  task automatic t_restart8();
    cyc(1'b1, 1'b0, "R3");
    cyc(1'b1, 1'b0, "R3");
    cyc(1'b0, 1'b0, "R9");
    cyc(1'b1, 1'b0, "R10");
    chk("R10", "restart comma", 32'(sym8), 32'(10'h0FA));
    cyc(1'b1, 1'b0, "R10");
    chk("R10", "restart second", 32'(sym8), 32'(10'h2AA));
    cyc(1'b0, 1'b0, "R9");
  endtask

  task automatic t_pattern16();
    cyc(1'b0, 1'b1, "R4");
    chk("R4", "first pair", 32'(sym16), 32'({10'h2AA, 10'h0FA}));
    cyc(1'b0, 1'b1, "R4");
    chk("R4", "second pair", 32'(sym16), 32'({10'h155, 10'h305}));
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, "R6");
  endtask

  task automatic t_force16();
    cyc(1'b0, 1'b0, "R9");
    chk("R7", "carried rd 2-lane", 32'(rd16), 1);
    cyc(1'b0, 1'b1, "R7");
    chk("R7", "forced pair", 32'(sym16), 32'({10'h2AA, 10'h0FA}));
    chk("R8", "upper force bit", 32'(frc16[1]), 0);
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, "R6");
    cyc(1'b0, 1'b0, "R9");
  endtask

  task automatic t_both();
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1, "R3");
    cyc(1'b0, 1'b0, "R10");
    cyc(1'b1, 1'b1, "R10");
    cyc(1'b0, 1'b0, "R9");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_idle();
    t_pattern8();
    t_force8();
    t_restart8();
    t_pattern16();
    t_force16();
    t_both();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule